// File: doc/BRIEF.md
# Display Controller Register and Interrupt Block

This block is the control-register front end of a display controller. Software reaches it through one 32-bit register port with a combinational read path. It stores the programmed picture parameters: output sizes for the panel path and the digital path, one overlay's base address, position, size, attributes, FIFO threshold and memory increments, two background colours and two transparency key colours. It also owns the interrupt status, the interrupt enables and the interrupt line.

Overlay settings are written into a shadow set. Software requests a commit for one path by writing that path's go bit. The shadow set is then copied into that path's active set at the next frame-start pulse of the path, and the go bit clears itself. The downstream fetch and timing logic uses only the active sets, so a frame never sees a half-updated configuration. A palette-load completion pulse steps the load-mode field back by itself.

Top module: `dispctl_regs`

## Requirements
- R1: Each bit of `evt_i` that is high at a clock edge sets the same bit of the 16-bit interrupt status (offset 0x08). Bit 0 is the frame-done event. A set bit stays set until it is cleared. When a set and a clear hit the same bit in the same cycle, the set wins.
- R2: Writing to offset 0x08 clears every status bit whose data bit is 1. Status bits whose data bit is 0 are left as they were.
- R3: The interrupt enable register (offset 0x0C) keeps data bits 15:0 and reads zero above them. `irq_o` is high exactly when some bit is set in both status and enable.
- R4: The control register (offset 0x10) keeps the written value ANDed with 0x07FF9FFF. Bit 0 drives `lcd_on_o`, bit 1 drives `dig_on_o`, and bit 11 drives `bus_mode_o`.
- R5: The size registers (panel output 0x30, digital output 0x34, overlay 0x40) hold width minus one in bits 10:0 and height minus one in bits 26:16. The overlay position register (0x3C) holds X in bits 10:0 and Y in bits 26:16. All other bits of these registers read zero, and the output sizes drive `lcd_size_o` and `dig_size_o` in the same layout.
- R6: Control bit 5 is the panel go bit and bit 6 is the digital go bit. Once written as 1, a go bit reads back 1 and is not cancelled by a later write of 0. It clears in the cycle in which that path's frame-start input (`lcd_frame_i` or `dig_frame_i`) is seen high.
- R7: At that frame start, the shadow overlay set is copied into the path's active output (`lcd_cfg_o` or `dig_cfg_o`). At no other time do the active outputs change, whether from shadow writes or from frame starts with no go pending. The active vector is packed from MSB to LSB as base[31:0], position[31:0], size[31:0], threshold[31:0], row increment[31:0], pixel increment[31:0], window skip[31:0], attributes[10:0]. The shadow fields are written at base 0x38, threshold 0x48, row increment 0x4C, pixel increment 0x50 and window skip 0x54.
- R8: The configuration register (0x14) keeps bits 13:0. On `pal_done_i`, load-mode bits 2:1 go from 01 to 00 and from 11 to 10, and are left unchanged otherwise. A register write in the same cycle takes precedence.
- R9: Field widths: capability (0x18) keeps 10 bits and resets to 0x161. Background colours (0x1C, 0x20) and key colours (0x24, 0x28) keep 24 bits. The line number (0x2C) keeps 11 bits. The overlay attributes (0x44; bit 0 enable, bits 4:1 pixel format) keep 11 bits. The threshold (0x48) is masked with 0x01FF01FF.
- R10: After reset, every size field is 0 (meaning 1x1), both increments are 1, the window skip is 0, the interrupt enable and status are 0, both go bits are 0, and both active sets hold these values.
- R11: Writing offset 0x00 with data bit 1 set returns every register to its reset value at that edge. Otherwise offset 0x00 keeps data ANDed with 0x19. Offset 0x04 always reads 1 (reset done).
- R12: Writes to read-only or unmapped offsets change nothing, and reads from unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | ADDR_W | Byte offset of the register access |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| evt_i | input | IRQ_W | Interrupt event pulses, bit 0 frame done |
| lcd_frame_i | input | 1 | Panel path frame-start pulse |
| dig_frame_i | input | 1 | Digital path frame-start pulse |
| pal_done_i | input | 1 | Palette load completed |
| irq_o | output | 1 | Interrupt request |
| lcd_on_o | output | 1 | Panel output enable |
| dig_on_o | output | 1 | Digital output enable |
| bus_mode_o | output | 1 | Parallel panel bus mode select |
| lcd_size_o | output | 32 | Panel output size, minus-one encoded |
| dig_size_o | output | 32 | Digital output size, minus-one encoded |
| lcd_cfg_o | output | CFG_W | Active overlay set of the panel path |
| dig_cfg_o | output | CFG_W | Active overlay set of the digital path |

## Verification
The bench aims at the cycles in which two agents touch the same state. An event and a write-one-to-clear land on one status bit together, and a design that let the clear win would lose an interrupt. A go bit is rewritten as 0 while its commit is pending, and a design that cancelled it would never update the active set. A frame start arrives with no go pending, or on the other path, and a design that copied unconditionally would tear the displayed overlay. The bench also steps both load-mode values through a palette-done pulse, where a design that reverted 11 to 00 would drop the mode's upper bit. It checks that a soft reset restores the capability value rather than zeroing it.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;

    localparam int REG_W = 32;

    // register byte offsets
    localparam logic [7:0] OFF_SYSCFG   = 8'h00;
    localparam logic [7:0] OFF_SYSSTAT  = 8'h04;
    localparam logic [7:0] OFF_IRQSTAT  = 8'h08;
    localparam logic [7:0] OFF_IRQEN    = 8'h0C;
    localparam logic [7:0] OFF_CTRL     = 8'h10;
    localparam logic [7:0] OFF_CONFIG   = 8'h14;
    localparam logic [7:0] OFF_CAPS     = 8'h18;
    localparam logic [7:0] OFF_BG0      = 8'h1C;
    localparam logic [7:0] OFF_BG1      = 8'h20;
    localparam logic [7:0] OFF_KEY0     = 8'h24;
    localparam logic [7:0] OFF_KEY1     = 8'h28;
    localparam logic [7:0] OFF_LINE     = 8'h2C;
    localparam logic [7:0] OFF_LCDSZ    = 8'h30;
    localparam logic [7:0] OFF_DIGSZ    = 8'h34;
    localparam logic [7:0] OFF_OVBASE   = 8'h38;
    localparam logic [7:0] OFF_OVPOS    = 8'h3C;
    localparam logic [7:0] OFF_OVSIZE   = 8'h40;
    localparam logic [7:0] OFF_OVATTR   = 8'h44;
    localparam logic [7:0] OFF_OVTHR    = 8'h48;
    localparam logic [7:0] OFF_ROWINC   = 8'h4C;
    localparam logic [7:0] OFF_PIXINC   = 8'h50;
    localparam logic [7:0] OFF_WINSKIP  = 8'h54;

    // write masks and reset values
    localparam logic [31:0] MASK_CTRL   = 32'h07FF_9FFF;
    localparam logic [31:0] MASK_XY     = 32'h07FF_07FF;
    localparam logic [31:0] MASK_THR    = 32'h01FF_01FF;
    localparam logic [4:0]  MASK_SYSCFG = 5'h19;
    localparam int          CONFIG_W    = 14;
    localparam int          CAPS_W      = 10;
    localparam logic [9:0]  CAPS_RESET  = 10'h161;
    localparam int          COLOUR_W    = 24;
    localparam int          LINE_W      = 11;
    localparam int          ATTR_W      = 11;

    // control register bit positions
    localparam int CTRL_LCD_ON  = 0;
    localparam int CTRL_DIG_ON  = 1;
    localparam int CTRL_BUSMODE = 11;
    localparam int SYSCFG_SRST  = 1;

    typedef enum logic [0:0] {
        PATH_LCD = 1'b0,
        PATH_DIG = 1'b1
    } path_e;

    localparam int NPATH = 2;

    typedef struct packed {
        logic [31:0]       base;
        logic [31:0]       pos;
        logic [31:0]       size;
        logic [31:0]       thresh;
        logic [31:0]       rowinc;
        logic [31:0]       pixinc;
        logic [31:0]       winskip;
        logic [ATTR_W-1:0] attr;
    } ovl_cfg_t;

    localparam int CFG_W = $bits(ovl_cfg_t);

    function automatic ovl_cfg_t ovl_reset();
        ovl_cfg_t c;
        c         = '0;
        c.rowinc  = 32'd1;
        c.pixinc  = 32'd1;
        return c;
    endfunction

    // control bit that requests a commit on a given path
    function automatic int go_bit(input path_e p);
        return (p == PATH_LCD) ? 5 : 6;
    endfunction

    // palette completion steps the two-bit load mode back
    function automatic logic [1:0] loadmode_after_palette(input logic [1:0] m);
        case (m)
            2'b01:   return 2'b00;
            2'b11:   return 2'b10;
            default: return m;
        endcase
    endfunction

endpackage

// File: rtl/dispctl_irq.sv
module dispctl_irq #(
    parameter int IRQ_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IRQ_W-1:0] set_i,
    input  logic [IRQ_W-1:0] clr_i,
    input  logic             en_we_i,
    input  logic [IRQ_W-1:0] en_d_i,
    output logic [IRQ_W-1:0] status_o,
    output logic [IRQ_W-1:0] enable_o,
    output logic             irq_o
);

    logic [IRQ_W-1:0] status_q;
    logic [IRQ_W-1:0] enable_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_i) | set_i;
            if (en_we_i) begin
                enable_q <= en_d_i;
            end
        end
    end

    assign status_o = status_q;
    assign enable_o = enable_q;
    assign irq_o    = |(status_q & enable_q);

    // R1: an event sets its bit, even against a clear in the same cycle
    a_r1_event_sets: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));

    // R1: set bits that are not cleared stay set
    a_r1_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & $past(status_q & ~clr_i)) == $past(status_q & ~clr_i)));

    // R2: a clear without a competing event empties the bit
    a_r2_w1c: assert property (@(posedge clk) disable iff (rst)
        ((clr_i & ~set_i) != '0) |=> ((status_q & $past(clr_i & ~set_i)) == '0));

endmodule

// File: rtl/dispctl_commit.sv
module dispctl_commit
    import dispctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     go_set_i,
    input  logic     frame_i,
    input  ovl_cfg_t shadow_i,
    output logic     go_o,
    output ovl_cfg_t active_o
);

    logic     go_q;
    ovl_cfg_t active_q;
    logic     fire;

    assign fire = go_q & frame_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            go_q     <= 1'b0;
            active_q <= ovl_reset();
        end else begin
            go_q <= (go_q & ~frame_i) | go_set_i;
            if (fire) begin
                active_q <= shadow_i;
            end
        end
    end

    assign go_o     = go_q;
    assign active_o = active_q;

    // R6/R7: a pending go meeting a frame start loads the shadow set and retires
    a_r6_commit: assert property (@(posedge clk) disable iff (rst)
        (go_q && frame_i) |=> ((!go_q || $past(go_set_i)) && active_q == $past(shadow_i)));

    // R7: without a commit the active set holds
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !(go_q && frame_i) |=> (active_q == $past(active_q)));

    // R6: a go request is never lost before its frame start
    a_r6_pending: assert property (@(posedge clk) disable iff (rst)
        (go_q && !frame_i) |=> go_q);

endmodule

// File: rtl/dispctl_regs.sv
module dispctl_regs
    import dispctl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IRQ_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    input  logic [IRQ_W-1:0]  evt_i,
    input  logic              lcd_frame_i,
    input  logic              dig_frame_i,
    input  logic              pal_done_i,
    output logic              irq_o,
    output logic              lcd_on_o,
    output logic              dig_on_o,
    output logic              bus_mode_o,
    output logic [31:0]       lcd_size_o,
    output logic [31:0]       dig_size_o,
    output logic [CFG_W-1:0]  lcd_cfg_o,
    output logic [CFG_W-1:0]  dig_cfg_o
);

    localparam int EN_KEEP = (IRQ_W < REG_W) ? IRQ_W : REG_W;

    // ---------------- write decode ----------------
    logic w_sys, w_stat, w_en, w_ctrl, w_cfg, w_caps;
    logic w_bg0, w_bg1, w_key0, w_key1, w_line, w_lcdsz, w_digsz;
    logic w_base, w_pos, w_osz, w_attr, w_thr, w_rinc, w_pinc, w_skip;
    logic srst, rst_all;

    assign w_sys   = bus_we_i && (bus_addr_i == ADDR_W'(OFF_SYSCFG));
    assign w_stat  = bus_we_i && (bus_addr_i == ADDR_W'(OFF_IRQSTAT));
    assign w_en    = bus_we_i && (bus_addr_i == ADDR_W'(OFF_IRQEN));
    assign w_ctrl  = bus_we_i && (bus_addr_i == ADDR_W'(OFF_CTRL));
    assign w_cfg   = bus_we_i && (bus_addr_i == ADDR_W'(OFF_CONFIG));
    assign w_caps  = bus_we_i && (bus_addr_i == ADDR_W'(OFF_CAPS));
    assign w_bg0   = bus_we_i && (bus_addr_i == ADDR_W'(OFF_BG0));
    assign w_bg1   = bus_we_i && (bus_addr_i == ADDR_W'(OFF_BG1));
    assign w_key0  = bus_we_i && (bus_addr_i == ADDR_W'(OFF_KEY0));
    assign w_key1  = bus_we_i && (bus_addr_i == ADDR_W'(OFF_KEY1));
    assign w_line  = bus_we_i && (bus_addr_i == ADDR_W'(OFF_LINE));
    assign w_lcdsz = bus_we_i && (bus_addr_i == ADDR_W'(OFF_LCDSZ));
    assign w_digsz = bus_we_i && (bus_addr_i == ADDR_W'(OFF_DIGSZ));
    assign w_base  = bus_we_i && (bus_addr_i == ADDR_W'(OFF_OVBASE));
    assign w_pos   = bus_we_i && (bus_addr_i == ADDR_W'(OFF_OVPOS));
    assign w_osz   = bus_we_i && (bus_addr_i == ADDR_W'(OFF_OVSIZE));
    assign w_attr  = bus_we_i && (bus_addr_i == ADDR_W'(OFF_OVATTR));
    assign w_thr   = bus_we_i && (bus_addr_i == ADDR_W'(OFF_OVTHR));
    assign w_rinc  = bus_we_i && (bus_addr_i == ADDR_W'(OFF_ROWINC));
    assign w_pinc  = bus_we_i && (bus_addr_i == ADDR_W'(OFF_PIXINC));
    assign w_skip  = bus_we_i && (bus_addr_i == ADDR_W'(OFF_WINSKIP));

    // soft reset acts at the edge of the write that requests it
    assign srst    = w_sys && bus_wdata_i[SYSCFG_SRST];
    assign rst_all = rst || srst;

    // ---------------- storage ----------------
    logic [4:0]          syscfg_q;
    logic [31:0]         ctrl_q;      // go bits are kept in the commit units
    logic [CONFIG_W-1:0] config_q;
    logic [CAPS_W-1:0]   caps_q;
    logic [COLOUR_W-1:0] bg_q   [2];
    logic [COLOUR_W-1:0] key_q  [2];
    logic [LINE_W-1:0]   line_q;
    logic [31:0]         lcdsz_q;
    logic [31:0]         digsz_q;
    ovl_cfg_t            shadow_q;

    logic [31:0] ctrl_keep;
    assign ctrl_keep = MASK_CTRL & ~((32'd1 << go_bit(PATH_LCD)) | (32'd1 << go_bit(PATH_DIG)));

    always_ff @(posedge clk) begin
        if (rst_all) begin
            syscfg_q <= '0;
            ctrl_q   <= '0;
            config_q <= '0;
            caps_q   <= CAPS_RESET;
            bg_q[0]  <= '0;
            bg_q[1]  <= '0;
            key_q[0] <= '0;
            key_q[1] <= '0;
            line_q   <= '0;
            lcdsz_q  <= '0;
            digsz_q  <= '0;
            shadow_q <= ovl_reset();
        end else begin
            if (w_sys)   syscfg_q <= bus_wdata_i[4:0] & MASK_SYSCFG;
            if (w_ctrl)  ctrl_q   <= bus_wdata_i & ctrl_keep;
            if (w_cfg) begin
                config_q <= bus_wdata_i[CONFIG_W-1:0];
            end else if (pal_done_i) begin
                config_q[2:1] <= loadmode_after_palette(config_q[2:1]);
            end
            if (w_caps)  caps_q   <= bus_wdata_i[CAPS_W-1:0];
            if (w_bg0)   bg_q[0]  <= bus_wdata_i[COLOUR_W-1:0];
            if (w_bg1)   bg_q[1]  <= bus_wdata_i[COLOUR_W-1:0];
            if (w_key0)  key_q[0] <= bus_wdata_i[COLOUR_W-1:0];
            if (w_key1)  key_q[1] <= bus_wdata_i[COLOUR_W-1:0];
            if (w_line)  line_q   <= bus_wdata_i[LINE_W-1:0];
            if (w_lcdsz) lcdsz_q  <= bus_wdata_i & MASK_XY;
            if (w_digsz) digsz_q  <= bus_wdata_i & MASK_XY;
            if (w_base)  shadow_q.base    <= bus_wdata_i;
            if (w_pos)   shadow_q.pos     <= bus_wdata_i & MASK_XY;
            if (w_osz)   shadow_q.size    <= bus_wdata_i & MASK_XY;
            if (w_attr)  shadow_q.attr    <= bus_wdata_i[ATTR_W-1:0];
            if (w_thr)   shadow_q.thresh  <= bus_wdata_i & MASK_THR;
            if (w_rinc)  shadow_q.rowinc  <= bus_wdata_i;
            if (w_pinc)  shadow_q.pixinc  <= bus_wdata_i;
            if (w_skip)  shadow_q.winskip <= bus_wdata_i;
        end
    end

    // ---------------- interrupt unit ----------------
    logic [IRQ_W-1:0] irq_status, irq_enable, irq_clr, en_d;

    assign irq_clr = w_stat ? bus_wdata_i[IRQ_W-1:0] : '0;
    assign en_d    = IRQ_W'(bus_wdata_i[EN_KEEP-1:0]);

    dispctl_irq #(.IRQ_W(IRQ_W)) u_irq (
        .clk      (clk),
        .rst      (rst_all),
        .set_i    (evt_i),
        .clr_i    (irq_clr),
        .en_we_i  (w_en),
        .en_d_i   (en_d),
        .status_o (irq_status),
        .enable_o (irq_enable),
        .irq_o    (irq_o)
    );

    // ---------------- per-path commit units ----------------
    logic     [NPATH-1:0] go_set, frame_in, go_pend;
    ovl_cfg_t             active [NPATH];

    assign frame_in = {dig_frame_i, lcd_frame_i};

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        assign go_set[p] = w_ctrl && bus_wdata_i[go_bit(path_e'(p))];

        dispctl_commit u_commit (
            .clk      (clk),
            .rst      (rst_all),
            .go_set_i (go_set[p]),
            .frame_i  (frame_in[p]),
            .shadow_i (shadow_q),
            .go_o     (go_pend[p]),
            .active_o (active[p])
        );
    end

    assign lcd_cfg_o  = active[PATH_LCD];
    assign dig_cfg_o  = active[PATH_DIG];
    assign lcd_on_o   = ctrl_q[CTRL_LCD_ON];
    assign dig_on_o   = ctrl_q[CTRL_DIG_ON];
    assign bus_mode_o = ctrl_q[CTRL_BUSMODE];
    assign lcd_size_o = lcdsz_q;
    assign dig_size_o = digsz_q;

    // ---------------- read mux ----------------
    logic [31:0] ctrl_rd;
    assign ctrl_rd = ctrl_q
                   | (32'(go_pend[PATH_LCD]) << go_bit(PATH_LCD))
                   | (32'(go_pend[PATH_DIG]) << go_bit(PATH_DIG));

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            ADDR_W'(OFF_SYSCFG):  bus_rdata_o = 32'(syscfg_q);
            ADDR_W'(OFF_SYSSTAT): bus_rdata_o = 32'd1;
            ADDR_W'(OFF_IRQSTAT): bus_rdata_o = 32'(irq_status);
            ADDR_W'(OFF_IRQEN):   bus_rdata_o = 32'(irq_enable);
            ADDR_W'(OFF_CTRL):    bus_rdata_o = ctrl_rd;
            ADDR_W'(OFF_CONFIG):  bus_rdata_o = 32'(config_q);
            ADDR_W'(OFF_CAPS):    bus_rdata_o = 32'(caps_q);
            ADDR_W'(OFF_BG0):     bus_rdata_o = 32'(bg_q[0]);
            ADDR_W'(OFF_BG1):     bus_rdata_o = 32'(bg_q[1]);
            ADDR_W'(OFF_KEY0):    bus_rdata_o = 32'(key_q[0]);
            ADDR_W'(OFF_KEY1):    bus_rdata_o = 32'(key_q[1]);
            ADDR_W'(OFF_LINE):    bus_rdata_o = 32'(line_q);
            ADDR_W'(OFF_LCDSZ):   bus_rdata_o = lcdsz_q;
            ADDR_W'(OFF_DIGSZ):   bus_rdata_o = digsz_q;
            ADDR_W'(OFF_OVBASE):  bus_rdata_o = shadow_q.base;
            ADDR_W'(OFF_OVPOS):   bus_rdata_o = shadow_q.pos;
            ADDR_W'(OFF_OVSIZE):  bus_rdata_o = shadow_q.size;
            ADDR_W'(OFF_OVATTR):  bus_rdata_o = 32'(shadow_q.attr);
            ADDR_W'(OFF_OVTHR):   bus_rdata_o = shadow_q.thresh;
            ADDR_W'(OFF_ROWINC):  bus_rdata_o = shadow_q.rowinc;
            ADDR_W'(OFF_PIXINC):  bus_rdata_o = shadow_q.pixinc;
            ADDR_W'(OFF_WINSKIP): bus_rdata_o = shadow_q.winskip;
            default:              bus_rdata_o = '0;
        endcase
    end

    // R4: output enables follow the written control value
    a_r4_enables: assert property (@(posedge clk) disable iff (rst_all)
        w_ctrl |=> (lcd_on_o == $past(bus_wdata_i[CTRL_LCD_ON])
                    && dig_on_o == $past(bus_wdata_i[CTRL_DIG_ON])));

    // R8: mode 01 returns to 00 after a palette load
    a_r8_pal_low: assert property (@(posedge clk) disable iff (rst_all)
        (pal_done_i && !w_cfg && config_q[2:1] == 2'b01) |=> (config_q[2:1] == 2'b00));

    // R8: mode 11 returns to 10 after a palette load
    a_r8_pal_high: assert property (@(posedge clk) disable iff (rst_all)
        (pal_done_i && !w_cfg && config_q[2:1] == 2'b11) |=> (config_q[2:1] == 2'b10));

    // R5: the overlay size never holds bits outside its two 11-bit fields
    a_r5_size_fields: assert property (@(posedge clk) disable iff (rst_all)
        w_osz |=> ((shadow_q.size & ~MASK_XY) == '0));

endmodule

// File: tb/dispctl_regs_tb.sv
module dispctl_regs_tb;
    import dispctl_pkg::*;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 8;
    localparam int IRQ_W  = 16;
    localparam int NVEC   = 15;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic              we = 1'b0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [IRQ_W-1:0]  evt = '0;
    logic              lcd_frame = 1'b0, dig_frame = 1'b0, pal_done = 1'b0;
    logic              irq, lcd_on, dig_on, bus_mode;
    logic [31:0]       lcd_size, dig_size;
    logic [CFG_W-1:0]  lcd_cfg, dig_cfg;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    dispctl_regs #(.ADDR_W(ADDR_W), .IRQ_W(IRQ_W)) u_dut (
        .clk(clk), .rst(rst), .bus_addr_i(addr), .bus_we_i(we),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .evt_i(evt),
        .lcd_frame_i(lcd_frame), .dig_frame_i(dig_frame), .pal_done_i(pal_done),
        .irq_o(irq), .lcd_on_o(lcd_on), .dig_on_o(dig_on), .bus_mode_o(bus_mode),
        .lcd_size_o(lcd_size), .dig_size_o(dig_size),
        .lcd_cfg_o(lcd_cfg), .dig_cfg_o(dig_cfg)
    );

    // {offset, write data, expected readback, requirement number}
    localparam logic [79:0] VEC [NVEC] = '{
        {8'h10, 32'hFFFF_FF9F, 32'h07FF_9F9F, 8'd4},   // R4 control mask
        {8'h0C, 32'hFFFF_FFFF, 32'h0000_FFFF, 8'd3},   // R3 enable width
        {8'h14, 32'hFFFF_FFFF, 32'h0000_3FFF, 8'd8},   // R8 config width
        {8'h18, 32'hFFFF_FFFF, 32'h0000_03FF, 8'd9},   // R9 capability width
        {8'h1C, 32'hFFFF_FFFF, 32'h00FF_FFFF, 8'd9},   // R9 background colour
        {8'h28, 32'hAB12_3456, 32'h0012_3456, 8'd9},   // R9 key colour
        {8'h2C, 32'h0000_FFFF, 32'h0000_07FF, 8'd9},   // R9 line number
        {8'h40, 32'hFFFF_FFFF, 32'h07FF_07FF, 8'd5},   // R5 overlay size
        {8'h3C, 32'h1234_5678, 32'h0234_0678, 8'd5},   // R5 overlay position
        {8'h30, 32'h00EF_013F, 32'h00EF_013F, 8'd5},   // R5 panel size
        {8'h44, 32'h0000_FFFF, 32'h0000_07FF, 8'd9},   // R9 attributes
        {8'h48, 32'hFFFF_FFFF, 32'h01FF_01FF, 8'd9},   // R9 threshold
        {8'h00, 32'h0000_00FD, 32'h0000_0019, 8'd11},  // R11 sysconfig mask
        {8'h04, 32'h0000_0000, 32'h0000_0001, 8'd11},  // R11 / R12 status read-only
        {8'hF0, 32'hFFFF_FFFF, 32'h0000_0000, 8'd12}   // R12 unmapped
    };

    task automatic chk(input logic [255:0] act, input logic [255:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic wr_evt(input logic [7:0] a, input logic [31:0] d, input logic [IRQ_W-1:0] e);
        @(negedge clk); addr = a; wdata = d; we = 1'b1; evt = e;
        @(negedge clk); we = 1'b0; evt = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string req);
        @(negedge clk); addr = a; #1;
        chk(256'(rdata), 256'(e), req);
    endtask

    task automatic pulse_evt(input logic [IRQ_W-1:0] e);
        @(negedge clk); evt = e;
        @(negedge clk); evt = '0;
    endtask

    task automatic pulse_lcd();
        @(negedge clk); lcd_frame = 1'b1;
        @(negedge clk); lcd_frame = 1'b0;
    endtask

    task automatic pulse_dig();
        @(negedge clk); dig_frame = 1'b1;
        @(negedge clk); dig_frame = 1'b0;
    endtask

    task automatic pulse_pal();
        @(negedge clk); pal_done = 1'b1;
        @(negedge clk); pal_done = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    function automatic logic [CFG_W-1:0] cfg_vec(
        input logic [31:0] b, input logic [31:0] p, input logic [31:0] s,
        input logic [31:0] t, input logic [31:0] ri, input logic [31:0] pi,
        input logic [31:0] ws, input logic [10:0] at);
        return {b, p, s, t, ri, pi, ws, at};
    endfunction

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [CFG_W-1:0] rst_cfg, cfg_a, cfg_b;
        rst_cfg = cfg_vec(32'd0, 32'd0, 32'd0, 32'd0, 32'd1, 32'd1, 32'd0, 11'd0);

        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R10 reset state
        rd(8'h18, 32'h161, "R10 caps");
        rd(8'h4C, 32'd1,   "R10 rowinc");
        rd(8'h50, 32'd1,   "R10 pixinc");
        rd(8'h54, 32'd0,   "R10 winskip");
        rd(8'h0C, 32'd0,   "R10 irq enable");
        rd(8'h40, 32'd0,   "R10 overlay size");
        rd(8'h10, 32'd0,   "R10 control");
        chk(256'(irq), 256'(0), "R10 irq");
        chk(256'(lcd_cfg), 256'(rst_cfg), "R10 lcd active");
        chk(256'(dig_cfg), 256'(rst_cfg), "R10 dig active");

        // table of write / readback pairs
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][79:72], VEC[i][71:40]);
            @(negedge clk); addr = VEC[i][79:72]; #1;
            n_chk++;
            if (rdata !== VEC[i][39:8]) begin
                n_fail++;
                $display("FAIL R%0d offset %0h actual=%0h expected=%0h",
                         VEC[i][7:0], VEC[i][79:72], rdata, VEC[i][39:8]);
            end
        end
        chk(256'(lcd_size), 256'(32'h00EF_013F), "R5 lcd_size_o");
        chk(256'({bus_mode, dig_on, lcd_on}), 256'(3'b111), "R4 enables");

        // R11 soft reset restores reset values
        wr(8'h00, 32'h2);
        rd(8'h18, 32'h161, "R11 caps after soft reset");
        rd(8'h0C, 32'd0,   "R11 enable after soft reset");
        rd(8'h00, 32'd0,   "R11 sysconfig after soft reset");
        rd(8'h40, 32'd0,   "R11 overlay size after soft reset");
        chk(256'(lcd_on), 256'(0), "R11 lcd_on after soft reset");

        // R1 R2 R3 interrupts
        wr(8'h0C, 32'h0005);
        pulse_evt(16'h0001);
        rd(8'h08, 32'h1, "R1 frame done sets bit 0");
        chk(256'(irq), 256'(1), "R3 irq on enabled bit");
        pulse_evt(16'h0002);
        rd(8'h08, 32'h3, "R1 sticky accumulation");
        wr(8'h08, 32'h1);
        rd(8'h08, 32'h2, "R2 clear bit 0 only");
        chk(256'(irq), 256'(0), "R3 irq low with only masked bit");
        wr_evt(8'h08, 32'h4, 16'h0004);
        rd(8'h08, 32'h6, "R1 event beats clear");
        chk(256'(irq), 256'(1), "R3 irq after event wins");
        wr(8'h08, 32'hFFFF);
        rd(8'h08, 32'h0, "R2 clear all");

        // R6 R7 commit
        wr(8'h38, 32'h8000_1000);
        wr(8'h3C, 32'h0010_0020);
        wr(8'h40, 32'h00EF_013F);
        wr(8'h44, 32'h0000_000D);
        wr(8'h48, 32'h0040_0080);
        wr(8'h4C, 32'd3);
        wr(8'h50, 32'd2);
        wr(8'h54, 32'd7);
        cfg_a = cfg_vec(32'h8000_1000, 32'h0010_0020, 32'h00EF_013F, 32'h0040_0080,
                        32'd3, 32'd2, 32'd7, 11'h00D);
        chk(256'(lcd_cfg), 256'(rst_cfg), "R7 shadow writes do not reach active");
        wr(8'h10, 32'h21);
        rd(8'h10, 32'h21, "R6 go reads back");
        chk(256'(lcd_on), 256'(1), "R4 lcd_on");
        wr(8'h10, 32'h01);
        rd(8'h10, 32'h21, "R6 go not cancelled by zero");
        chk(256'(lcd_cfg), 256'(rst_cfg), "R7 no copy before frame start");
        pulse_dig();
        chk(256'(lcd_cfg), 256'(rst_cfg), "R7 other path frame does not commit");
        pulse_lcd();
        chk(256'(lcd_cfg), 256'(cfg_a), "R7 commit at frame start");
        chk(256'(dig_cfg), 256'(rst_cfg), "R7 digital path untouched");
        rd(8'h10, 32'h01, "R6 go self clears");
        wr(8'h38, 32'h9000_0000);
        pulse_lcd();
        chk(256'(lcd_cfg), 256'(cfg_a), "R7 frame without go holds");
        cfg_b = cfg_vec(32'h9000_0000, 32'h0010_0020, 32'h00EF_013F, 32'h0040_0080,
                        32'd3, 32'd2, 32'd7, 11'h00D);
        wr(8'h10, 32'h40);
        rd(8'h10, 32'h40, "R6 digital go reads back");
        pulse_dig();
        chk(256'(dig_cfg), 256'(cfg_b), "R7 digital commit");
        chk(256'(lcd_cfg), 256'(cfg_a), "R7 panel path unaffected");
        rd(8'h10, 32'h00, "R6 digital go clears");

        // R4 bus mode bit
        wr(8'h10, 32'h800);
        chk(256'({bus_mode, dig_on, lcd_on}), 256'(3'b100), "R4 bus mode");

        // R8 palette load mode reversion
        wr(8'h14, 32'h2);
        pulse_pal();
        rd(8'h14, 32'h0, "R8 mode 01 to 00");
        wr(8'h14, 32'h6);
        pulse_pal();
        rd(8'h14, 32'h4, "R8 mode 11 to 10");
        wr(8'h14, 32'h4);
        pulse_pal();
        rd(8'h14, 32'h4, "R8 mode 10 unchanged");

        // R12 read-only offset write leaves neighbours alone
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h00, 32'h0, "R12 sysconfig untouched");
        rd(8'h08, 32'h0, "R12 status untouched");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule